// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets synchronous logic read and write a 512K x 8 asynchronous static RAM that has one shared bidirectional data bus. A client presents a single-byte request on a valid/ready handshake: a 19-bit address, a read/write flag and, for writes, one data byte. The controller drives the active-low chip select, output enable and write enable strobes, holds the address, and turns its own data-bus driver on and off. A read returns its byte together with a one-cycle valid strobe.

Every phase length is a whole number of system clock cycles. Each length is worked out during elaboration from the clock period and the speed grade of the memory. The controller keeps output enable high for the whole of a write. It waits until the memory's output can no longer be driving before it enables its own driver, so the bus never has two drivers.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip select, output enable and write enable are high, ready is high and the read valid strobe is low.
- R2: Ready is high only while the controller is idle. A request is taken on a clock edge where valid and ready are both high. While idle with no request, all three strobes stay high.
- R3: A read holds chip select and output enable low and write enable high for exactly RD cycles. RD is the largest of the cycle counts for read cycle time, address access time and output-enable access time.
- R4: Read data is sampled on the clock edge that ends the read phase. On the next cycle the read valid strobe is high for exactly one cycle with that byte, and ready returns on the cycle after that.
- R5: A write holds chip select and write enable low together for exactly PULSE cycles, with output enable high for the whole write. PULSE is the largest of the counts for write pulse width, select-to-end, address-to-end, and turnaround plus data setup. Write enable is never low while output enable is low.
- R6: The controller leaves the data bus released for the first TURN cycles of the write pulse. It then drives the write byte, unchanged, for at least DSU cycles before write enable rises. Its driver never turns on within TURN cycles after the memory last had its output enabled.
- R7: After the pulse, the controller keeps the strobes high and the data driven for a recovery of max(1, WC - PULSE) cycles. Pulse plus recovery is therefore at least the write cycle count WC. Ready returns PULSE + recovery + 2 cycles after the request is taken.
- R8: The address on the memory pins does not change while chip select is low.
- R9: Once chip select rises at the end of an access, it stays high for at least two cycles before the next access.
- R10: Each count is ceil(ns / clock period), with a floor of one cycle. Grade 0 uses 55 ns cycle and access, 30 ns output-enable access, 40 ns write pulse, 50 ns select-to-end and address-to-end, 25 ns data setup and 20 ns output release. Grade 1 uses 70, 35, 50, 60, 30 and 25 ns respectively. At a 5 ns clock, grade 0 gives RD=11, TURN=4, DSU=5, PULSE=10, WC=11 and a recovery of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle strobe marking read data |
| rsp_rdata | output | 8 | Byte read from memory |
| sram_addr | output | 19 | Address pins of the memory |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq | inout | 8 | Shared data bus |

## Verification
Counting from the edge that takes a request, the strobes change on the next edge. For a read, the valid strobe is due on cycle RD+1 and ready on cycle RD+2. For a write, write enable rises on cycle PULSE+1 and ready returns on cycle PULSE+recovery+2. The bench samples every output on the falling edge and numbers those samples from the acceptance edge, so each check compares against a cycle index that bench functions compute from the nanosecond figures. The memory model in the bench drives inverted data until the address access count has elapsed, and it keeps driving for TURN cycles after output enable is removed. A read sampled one edge early, or a driver turned on too soon, therefore changes a value the bench compares.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WR_TURN,
        ST_WR_DATA,
        ST_WR_REC,
        ST_GAP
    } ctl_state_e;

    typedef enum logic [3:0] {
        TM_RC,  // read cycle
        TM_AA,  // address access
        TM_OE,  // output enable access
        TM_WP,  // write pulse
        TM_CW,  // select to end of write
        TM_AW,  // address to end of write
        TM_DW,  // data setup to end of write
        TM_WC,  // write cycle
        TM_HZ   // output release
    } tm_sel_e;

    function automatic int unsigned tm_ns(int unsigned grade, tm_sel_e sel);
        int unsigned v;
        if (grade == 0) begin
            case (sel)
                TM_RC, TM_AA, TM_WC: v = 55;
                TM_OE:               v = 30;
                TM_WP:               v = 40;
                TM_CW, TM_AW:        v = 50;
                TM_DW:               v = 25;
                default:             v = 20;
            endcase
        end else begin
            case (sel)
                TM_RC, TM_AA, TM_WC: v = 70;
                TM_OE:               v = 35;
                TM_WP:               v = 50;
                TM_CW, TM_AW:        v = 60;
                TM_DW:               v = 30;
                default:             v = 25;
            endcase
        end
        return v;
    endfunction

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned imax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
module sram_phase_cnt #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));

    // a loaded phase always lasts at least one cycle
    p_load_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));
endmodule

// File: rtl/sram_dq_io.sv
`timescale 1ns/1ps
module sram_dq_io #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cap_en,
    inout  wire  [DATA_W-1:0] dq,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic              vld_d, vld_q;
    logic [DATA_W-1:0] dat_d, dat_q;

    assign dq = drv_en ? wdata : {DATA_W{1'bz}};

    always_comb begin
        vld_d = cap_en;
        dat_d = dat_q;
        if (cap_en) dat_d = dq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else begin
            vld_q <= vld_d;
            dat_q <= dat_d;
        end
    end

    assign rsp_valid = vld_q;
    assign rsp_rdata = dat_q;

    p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_no_cap_while_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !drv_en);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int CNT_W    = 4,
    parameter int RD_CYC   = 11,
    parameter int TURN_CYC = 4,
    parameter int DATA_CYC = 6,
    parameter int REC_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              cnt_last,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              cap_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              drv_en,
    output logic [DATA_W-1:0] drv_data
);
    localparam int PULSE_CYC = TURN_CYC + DATA_CYC;

    typedef struct packed {
        ctl_state_e        st;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } seq_t;

    seq_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cap_en   = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.addr  = req_addr;
                    nxt_d.wdata = req_wdata;
                    nxt_d.ce_n  = 1'b0;
                    cnt_load    = 1'b1;
                    if (req_write) begin
                        nxt_d.st   = ST_WR_TURN;
                        nxt_d.we_n = 1'b0;
                        cnt_val    = CNT_W'(TURN_CYC);
                    end else begin
                        nxt_d.st   = ST_RD;
                        nxt_d.oe_n = 1'b0;
                        cnt_val    = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_RD: begin
                if (cnt_last) begin
                    nxt_d.st   = ST_GAP;
                    nxt_d.ce_n = 1'b1;
                    nxt_d.oe_n = 1'b1;
                    cap_en     = 1'b1;
                end
            end
            ST_WR_TURN: begin
                if (cnt_last) begin
                    nxt_d.st  = ST_WR_DATA;
                    nxt_d.drv = 1'b1;
                    cnt_load  = 1'b1;
                    cnt_val   = CNT_W'(DATA_CYC);
                end
            end
            ST_WR_DATA: begin
                if (cnt_last) begin
                    nxt_d.st   = ST_WR_REC;
                    nxt_d.we_n = 1'b1;
                    nxt_d.ce_n = 1'b1;
                    cnt_load   = 1'b1;
                    cnt_val    = CNT_W'(REC_CYC);
                end
            end
            ST_WR_REC: begin
                if (cnt_last) begin
                    nxt_d.st  = ST_GAP;
                    nxt_d.drv = 1'b0;
                end
            end
            ST_GAP:  nxt_d.st = ST_IDLE;
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st    <= ST_IDLE;
            cur_q.ce_n  <= 1'b1;
            cur_q.oe_n  <= 1'b1;
            cur_q.we_n  <= 1'b1;
            cur_q.drv   <= 1'b0;
            cur_q.addr  <= '0;
            cur_q.wdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_ready = (cur_q.st == ST_IDLE);
    assign mem_addr  = cur_q.addr;
    assign ce_n      = cur_q.ce_n;
    assign oe_n      = cur_q.oe_n;
    assign we_n      = cur_q.we_n;
    assign drv_en    = cur_q.drv;
    assign drv_data  = cur_q.wdata;

    // length of the current write-enable low run, for the pulse check
    logic [CNT_W:0] wl_d, wl_q;
    always_comb wl_d = we_n ? '0 : wl_q + 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wl_q <= '0;
        else        wl_q <= wl_d;
    end

    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ce_n && oe_n && we_n));
    p_we_oe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);
    p_pulse_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (wl_q == (CNT_W+1)'(PULSE_CYC)));
    p_drv_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> oe_n);
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(mem_addr));
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ce_n) |=> ce_n);
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 5,
    parameter int SPEED_GRADE   = 0,
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    inout  wire  [DATA_W-1:0] sram_dq
);
    localparam int unsigned PER = CLK_PERIOD_NS;
    localparam int unsigned GR  = SPEED_GRADE;

    localparam int unsigned RD_CYC = imax(imax(ns_to_cyc(tm_ns(GR, TM_RC), PER),
                                               ns_to_cyc(tm_ns(GR, TM_AA), PER)),
                                          ns_to_cyc(tm_ns(GR, TM_OE), PER));
    localparam int unsigned TURN_CYC  = ns_to_cyc(tm_ns(GR, TM_HZ), PER);
    localparam int unsigned DSU_CYC   = ns_to_cyc(tm_ns(GR, TM_DW), PER);
    localparam int unsigned WC_CYC    = ns_to_cyc(tm_ns(GR, TM_WC), PER);
    localparam int unsigned PULSE_CYC = imax(imax(imax(ns_to_cyc(tm_ns(GR, TM_WP), PER),
                                                       ns_to_cyc(tm_ns(GR, TM_CW), PER)),
                                                  ns_to_cyc(tm_ns(GR, TM_AW), PER)),
                                             TURN_CYC + DSU_CYC);
    localparam int unsigned DATA_CYC  = PULSE_CYC - TURN_CYC;
    localparam int unsigned REC_CYC   = (WC_CYC > PULSE_CYC) ? WC_CYC - PULSE_CYC : 1;
    localparam int          CNT_W     = $clog2(imax(RD_CYC, PULSE_CYC) + 1);

    logic              cnt_load, cnt_last, cap_en, drv_en;
    logic [CNT_W-1:0]  cnt_val;
    logic [DATA_W-1:0] drv_data;

    sram_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    sram_ctl_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .RD_CYC   (int'(RD_CYC)),
        .TURN_CYC (int'(TURN_CYC)),
        .DATA_CYC (int'(DATA_CYC)),
        .REC_CYC  (int'(REC_CYC))
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .cnt_last  (cnt_last),
        .cnt_load  (cnt_load),
        .cnt_val   (cnt_val),
        .cap_en    (cap_en),
        .mem_addr  (sram_addr),
        .ce_n      (sram_ce_n),
        .oe_n      (sram_oe_n),
        .we_n      (sram_we_n),
        .drv_en    (drv_en),
        .drv_data  (drv_data)
    );

    sram_dq_io #(.DATA_W(DATA_W)) u_io (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_en    (drv_en),
        .wdata     (drv_data),
        .cap_en    (cap_en),
        .dq        (sram_dq),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // cycles since the memory last had its output enabled, saturating
    logic [CNT_W-1:0] rel_d, rel_q;
    always_comb begin
        rel_d = rel_q;
        if (!sram_ce_n && !sram_oe_n)       rel_d = '0;
        else if (rel_q < CNT_W'(TURN_CYC))  rel_d = rel_q + 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rel_q <= CNT_W'(TURN_CYC);
        else        rel_q <= rel_d;
    end

    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (rel_q >= CNT_W'(TURN_CYC)));
    p_rd_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    localparam int PER   = 5;
    localparam int GRADE = 0;

    // R10: expected counts worked out from the nanosecond figures
    function automatic int cyc(int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction
    localparam int E_RD    = (GRADE == 0) ? mx(cyc(55), cyc(30)) : mx(cyc(70), cyc(35));
    localparam int E_TURN  = (GRADE == 0) ? cyc(20) : cyc(25);
    localparam int E_DSU   = (GRADE == 0) ? cyc(25) : cyc(30);
    localparam int E_WC    = (GRADE == 0) ? cyc(55) : cyc(70);
    localparam int E_PULSE = mx(mx((GRADE == 0) ? cyc(40) : cyc(50),
                                   (GRADE == 0) ? cyc(50) : cyc(60)), E_TURN + E_DSU);
    localparam int E_REC   = (E_WC > E_PULSE) ? E_WC - E_PULSE : 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [18:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    wire  [7:0]  sram_dq;

    always #2.5 clk = ~clk;

    sram_ctl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(GRADE)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq(sram_dq)
    );

    // ---------------- memory model ----------------
    logic [7:0] mem     [int unsigned];
    logic [7:0] exp_mem [int unsigned];
    int   rd_age = 0;
    int   linger = 0;
    logic m_rd, m_drv;
    logic [7:0] m_val;

    function automatic logic [7:0] mem_at(int unsigned a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    always @* begin
        m_rd  = !sram_ce_n && !sram_oe_n && sram_we_n;
        m_drv = m_rd || (linger > 0);
        m_val = (m_rd && rd_age >= E_RD - 1) ? mem_at(sram_addr) : ~mem_at(sram_addr);
    end
    assign sram_dq = m_drv ? m_val : 8'hzz;

    always @(posedge clk) begin
        rd_age <= m_rd ? rd_age + 1 : 0;
        linger <= m_rd ? E_TURN : ((linger > 0) ? linger - 1 : 0);
    end

    // write capture at the falling edge
    int          wlen = 0, stab = 0;
    logic [7:0]  wlast = '0;
    logic [18:0] waddr = '0;
    bit          w_ev = 0;
    int          w_len = 0, w_stab = 0;
    always @(negedge clk) begin
        if (rst_n && !sram_ce_n && !sram_we_n) begin
            wlen++;
            if (wlen > 1 && sram_dq === wlast) stab++; else stab = 1;
            wlast = sram_dq;
            waddr = sram_addr;
        end else if (wlen > 0) begin
            mem[waddr] = wlast;
            w_ev = 1; w_len = wlen; w_stab = stab;
            wlen = 0; stab = 0;
        end
    end

    // ---------------- checking ----------------
    int total = 0, fails = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
        int n, ce_cnt, oe_cnt, rsp_at, rsp_cnt;
        bit addr_bad;
        logic [7:0] rsp_d;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready while idle", req_ready, 1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        n = 1; ce_cnt = 0; oe_cnt = 0; rsp_at = 0; rsp_cnt = 0; addr_bad = 0; rsp_d = '0;
        while (!req_ready && n < 100) begin
            if (!sram_ce_n) ce_cnt++;
            if (!sram_oe_n) oe_cnt++;
            if (!sram_ce_n && sram_addr != a) addr_bad = 1;
            if (rsp_valid) begin rsp_at = n; rsp_cnt++; rsp_d = rsp_rdata; end
            @(negedge clk);
            n++;
        end
        chk(!addr_bad, "R8 address held while selected", addr_bad, 0);
        if (!wr) begin
            chk(ce_cnt == E_RD && oe_cnt == E_RD, "R3 read strobe length", oe_cnt, E_RD);
            chk(rsp_cnt == 1 && rsp_at == E_RD + 1, "R4 read valid cycle", rsp_at, E_RD + 1);
            chk(rsp_d == exp_mem_at(a), "R4 read data", rsp_d, exp_mem_at(a));
            chk(n == E_RD + 2, "R4 ready return after read", n, E_RD + 2);
        end else begin
            exp_mem[a] = d;
            chk(ce_cnt == E_PULSE && w_ev && w_len == E_PULSE, "R5 write pulse length", w_len, E_PULSE);
            chk(oe_cnt == 0, "R5 output enable high in write", oe_cnt, 0);
            chk(rsp_cnt == 0, "R5 no read strobe on write", rsp_cnt, 0);
            chk(w_stab >= E_DSU, "R6 data stable before end of write", w_stab, E_DSU);
            chk(mem_at(a) == d, "R6 stored byte", mem_at(a), d);
            chk(n - 2 >= E_WC && n == E_PULSE + E_REC + 2, "R7 write cycle and ready return",
                n, E_PULSE + E_REC + 2);
            w_ev = 0;
        end
    endtask

    function automatic logic [7:0] exp_mem_at(int unsigned a);
        return exp_mem.exists(a) ? exp_mem[a] : 8'h00;
    endfunction

    // R9: select stays high two cycles between accesses
    int hi_run = 0;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sram_ce_n) hi_run++;
            else begin
                if (seen_low && hi_run > 0)
                    chk(hi_run >= 2, "R9 select high gap", hi_run, 2);
                hi_run = 0; seen_low = 1;
            end
        end
    end

    initial begin
        logic [18:0] pool [8];
        void'($urandom(32'h5EED_0042));
        // R10: counts at the default clock and grade
        chk(E_RD == 11 && E_PULSE == 10 && E_TURN == 4 && E_REC == 1,
            "R10 derived counts", E_PULSE, 10);
        repeat (3) @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !rsp_valid, "R1 strobes in reset",
            {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid, "R1 ready after reset", req_ready, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sram_ce_n && sram_oe_n && sram_we_n, "R2 idle strobes stay high",
                {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        end
        // directed corners
        do_req(1'b1, 19'h00000, 8'h5A);
        do_req(1'b1, 19'h7FFFF, 8'hA5);
        do_req(1'b0, 19'h00000, 8'h00);
        do_req(1'b0, 19'h7FFFF, 8'h00);
        do_req(1'b1, 19'h7FFFF, 8'hFF);
        do_req(1'b0, 19'h7FFFF, 8'h00);
        do_req(1'b1, 19'h12345, 8'h00);
        do_req(1'b0, 19'h12345, 8'h00);
        do_req(1'b0, 19'h2AAAA, 8'h00);
        // random mix over a small address pool
        pool[0] = 19'h00000; pool[1] = 19'h7FFFF;
        for (int i = 2; i < 8; i++) pool[i] = 19'($urandom);
        for (int i = 0; i < 60; i++) begin
            do_req(1'($urandom), pool[$urandom % 8], 8'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(200000 * PER);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule